// File: doc/BRIEF.md
# Packed Double-to-Int32 Converter

This block turns a 128-bit operand carrying two IEEE 754 double-precision numbers into a 64-bit word carrying two signed 32-bit integers. Each lane is converted on its own. A 2-bit rounding selector, sampled together with the operand, picks how inexact values are rounded. The block reports two exception kinds, merged across both lanes: invalid and precision (inexact).

An operation enters through a valid/ready handshake. Its result comes out of a single output register one cycle later. When a lane is invalid and the invalid mask input is high, that lane returns the integer-indefinite pattern 0x80000000. When the mask is low, the output register keeps its old contents and a one-cycle exception strobe is raised in place of a result.

A small controller with three states sequences the handshake:
- ST_EMPTY: nothing is held and the input is ready.
- ST_FULL: a result is being presented.
- ST_TRAP: the one-cycle exception strobe is active.

Its transitions are:
- ACCEPT_OK goes from ST_EMPTY or ST_FULL to ST_FULL when an operation is taken without an unmasked invalid.
- ACCEPT_TRAP goes from ST_EMPTY or ST_FULL to ST_TRAP when an operation is taken with an unmasked invalid.
- DRAIN goes from ST_FULL to ST_EMPTY when the result is taken and no new operation arrives.
- STALL keeps ST_FULL while the result is not taken.
- TRAP_DONE goes from ST_TRAP to ST_EMPTY unconditionally.

Top module: `pk_dbl_to_i32`

## Requirements
- R1: Result bits [31:0] are the conversion of operand bits [63:0], and result bits [63:32] are the conversion of operand bits [127:64]. The two lanes do not influence each other's value.
- R2: A double whose value is an integer within [-2^31, 2^31-1] converts to that integer in two's complement, with neither flag raised.
- R3: The rounding selector is encoded 00 = nearest with ties to even, 01 = toward negative infinity, 10 = toward positive infinity, 11 = toward zero.
- R4: out_prec is raised when some lane discarded nonzero fraction bits and that lane is not invalid. out_inv is the OR of the lane invalid conditions.
- R5: The range check is applied after rounding. A rounded value outside [-2^31, 2^31-1] makes the lane invalid. With the mask high, that lane returns 0x80000000.
- R6: A NaN of either kind (exponent field all ones, fraction nonzero) and either infinity make the lane invalid. With the mask high, that lane returns 0x80000000.
- R7: An exponent field of zero (either signed zero or a denormal) converts to 0 without invalid. It raises precision only when the fraction is nonzero.
- R8: in_ready is high in ST_EMPTY, and in ST_FULL while out_ready is high. An operation accepted at one clock edge is presented with out_valid high after that edge.
- R9: While out_valid is high and out_ready is low, out_valid, out_result and the flags stay unchanged and in_ready is low.
- R10: An accepted operation with an unmasked invalid leaves out_result unchanged and keeps out_valid low. It raises exc_strobe for exactly the one following cycle, with out_inv high and in_ready low.
- R11: After reset, out_valid and exc_strobe are low, in_ready is high, and out_result and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| in_opnd | input | 128 | Two packed doubles, lane 0 in bits [63:0] |
| in_rmode | input | 2 | Rounding selector |
| in_inv_mask | input | 1 | High masks invalid: return indefinite instead of trapping |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Result taken |
| out_result | output | 64 | Two packed int32 results, lane 0 in bits [31:0] |
| out_inv | output | 1 | Invalid flag of the last accepted operation |
| out_prec | output | 1 | Precision flag of the last accepted operation |
| exc_strobe | output | 1 | One-cycle unmasked-invalid exception |

## Verification
Values that are already integral, including the extremes of the 32-bit range, separate the exponent alignment from the rounding logic. Halfway and near-halfway fractions of both signs are run under all four rounding selectors, which separates ties-to-even from the directed modes. Operands a fraction away from +2^31 and -2^31 show that the range check comes after rounding. NaNs, infinities, denormals and signed zero cover the special encodings, and mixed lanes (one invalid, one inexact) exercise the flag merge. Stalled outputs and unmasked traps exercise the controller, and random operands clustered near ±2^31 are compared lane by lane against a real-arithmetic model.

// File: rtl/pk_cvt_pkg.sv
package pk_cvt_pkg;
    parameter int DBL_W = 64;
    parameter int EXP_W = 11;
    parameter int FRC_W = 52;
    parameter int INT_W = 32;
    parameter int EXP_BIAS = 1023;

    localparam int MAN_W = FRC_W + 1;
    localparam int FX_W  = MAN_W + INT_W;
    localparam int SH_W  = $clog2(INT_W + 1);
    localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'b00,
        ST_FULL  = 2'b01,
        ST_TRAP  = 2'b10
    } cvt_state_e;
endpackage

// File: rtl/dcvt_lane.sv
module dcvt_lane
    import pk_cvt_pkg::*;
(
    input  logic [DBL_W-1:0] dbl,
    input  rmode_e           rmode,
    output logic [INT_W-1:0] ival,
    output logic             lane_inv,
    output logic             lane_inexact
);
    logic             sgn;
    logic [EXP_W-1:0] expf;
    logic [FRC_W-1:0] frac;
    logic [MAN_W-1:0] mant;
    logic             is_special;
    logic             is_tiny;
    logic             too_big;
    logic             too_small;
    int               unb;
    logic [SH_W-1:0]  shamt;
    logic [FX_W-1:0]  fx;
    logic [INT_W-1:0] mag;
    logic             rbit;
    logic             sbit;
    logic             inc;
    logic [INT_W:0]   mag_r;
    logic             over;
    logic             raw_inexact;

    assign sgn  = dbl[DBL_W-1];
    assign expf = dbl[DBL_W-2 -: EXP_W];
    assign frac = dbl[FRC_W-1:0];
    assign mant = {1'b1, frac};

    // classification of the encoding
    always_comb begin
        is_special = &expf;
        is_tiny    = (expf == '0);
        unb        = int'(expf) - EXP_BIAS;
        too_big    = (unb >= INT_W);
        too_small  = (unb < -1);
        shamt      = SH_W'(unb + 1);
    end

    // alignment: integer part, round bit and sticky bit
    always_comb begin
        fx   = '0;
        mag  = '0;
        rbit = 1'b0;
        sbit = 1'b0;
        if (!is_special && !is_tiny && !too_big) begin
            if (too_small) begin
                sbit = 1'b1;
            end else begin
                fx   = FX_W'(mant) << shamt;
                mag  = fx[FX_W-1:MAN_W];
                rbit = fx[MAN_W-1];
                sbit = |fx[MAN_W-2:0];
            end
        end
    end

    // rounding increment selected by the rounding mode
    always_comb begin
        inc = 1'b0;
        unique case (rmode)
            RM_NEAR: inc = rbit & (sbit | mag[0]);
            RM_DOWN: inc = (rbit | sbit) & sgn;
            RM_UP:   inc = (rbit | sbit) & ~sgn;
            RM_ZERO: inc = 1'b0;
            default: inc = 1'b0;
        endcase
    end

    // range check after rounding and result selection
    always_comb begin
        mag_r = {1'b0, mag} + {{INT_W{1'b0}}, inc};
        if (sgn)
            over = mag_r[INT_W] | (mag_r[INT_W-1] & (|mag_r[INT_W-2:0]));
        else
            over = mag_r[INT_W] | mag_r[INT_W-1];
        lane_inv     = is_special | (~is_tiny & (too_big | over));
        raw_inexact  = is_tiny ? (|frac) : (rbit | sbit);
        lane_inexact = raw_inexact & ~lane_inv;
        if (lane_inv)
            ival = INDEF;
        else if (sgn)
            ival = -mag_r[INT_W-1:0];
        else
            ival = mag_r[INT_W-1:0];
    end
endmodule

// File: rtl/dcvt_merge.sv
module dcvt_merge
    import pk_cvt_pkg::*;
#(
    parameter int N_LANES = 2
) (
    input  logic [N_LANES-1:0][INT_W-1:0] lane_val,
    input  logic [N_LANES-1:0]            lane_inv,
    input  logic [N_LANES-1:0]            lane_inexact,
    output logic [N_LANES*INT_W-1:0]      packed_res,
    output logic                          any_inv,
    output logic                          any_prec
);
    for (genvar g = 0; g < N_LANES; g++) begin : g_pack
        assign packed_res[g*INT_W +: INT_W] = lane_val[g];
    end

    assign any_inv  = |lane_inv;
    assign any_prec = |lane_inexact;
endmodule

// File: rtl/dcvt_ctrl.sv
module dcvt_ctrl
    import pk_cvt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    input  logic trap_req,
    output logic in_ready,
    output logic out_valid,
    output logic exc_strobe,
    output logic load_res,
    output logic load_flags
);
    cvt_state_e state_q;
    cvt_state_e state_d;
    logic       accept;

    assign accept = in_valid & in_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_EMPTY;
        else
            state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (in_valid)
                    state_d = trap_req ? ST_TRAP : ST_FULL;
            end
            ST_FULL: begin
                if (out_ready) begin
                    if (in_valid)
                        state_d = trap_req ? ST_TRAP : ST_FULL;
                    else
                        state_d = ST_EMPTY;
                end
            end
            ST_TRAP: state_d = ST_EMPTY;
            default: state_d = ST_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        in_ready   = 1'b0;
        out_valid  = 1'b0;
        exc_strobe = 1'b0;
        unique case (state_q)
            ST_EMPTY: in_ready = 1'b1;
            ST_FULL: begin
                in_ready  = out_ready;
                out_valid = 1'b1;
            end
            ST_TRAP:  exc_strobe = 1'b1;
            default:  in_ready = 1'b0;
        endcase
        load_flags = accept;
        load_res   = accept & ~trap_req;
    end
endmodule

// File: rtl/pk_dbl_to_i32.sv
module pk_dbl_to_i32
    import pk_cvt_pkg::*;
#(
    parameter int N_LANES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [N_LANES*DBL_W-1:0]   in_opnd,
    input  logic [1:0]                 in_rmode,
    input  logic                       in_inv_mask,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [N_LANES*INT_W-1:0]   out_result,
    output logic                       out_inv,
    output logic                       out_prec,
    output logic                       exc_strobe
);
    localparam int RES_W = N_LANES * INT_W;

    logic [N_LANES-1:0][INT_W-1:0] lane_val;
    logic [N_LANES-1:0]            lane_inv;
    logic [N_LANES-1:0]            lane_inexact;
    logic [RES_W-1:0]              res_d;
    logic                          inv_d;
    logic                          prec_d;
    logic                          trap_req;
    logic                          load_res;
    logic                          load_flags;
    logic [RES_W-1:0]              res_q;
    logic                          inv_q;
    logic                          prec_q;
    rmode_e                        rmode;

    assign rmode = rmode_e'(in_rmode);

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        dcvt_lane u_lane (
            .dbl          (in_opnd[g*DBL_W +: DBL_W]),
            .rmode        (rmode),
            .ival         (lane_val[g]),
            .lane_inv     (lane_inv[g]),
            .lane_inexact (lane_inexact[g])
        );
    end

    dcvt_merge #(.N_LANES(N_LANES)) u_merge (
        .lane_val     (lane_val),
        .lane_inv     (lane_inv),
        .lane_inexact (lane_inexact),
        .packed_res   (res_d),
        .any_inv      (inv_d),
        .any_prec     (prec_d)
    );

    assign trap_req = inv_d & ~in_inv_mask;

    dcvt_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .out_ready  (out_ready),
        .trap_req   (trap_req),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .exc_strobe (exc_strobe),
        .load_res   (load_res),
        .load_flags (load_flags)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q  <= '0;
            inv_q  <= 1'b0;
            prec_q <= 1'b0;
        end else begin
            if (load_res)
                res_q <= res_d;
            if (load_flags) begin
                inv_q  <= inv_d;
                prec_q <= prec_d;
            end
        end
    end

    assign out_result = res_q;
    assign out_inv    = inv_q;
    assign out_prec   = prec_q;
endmodule

// File: rtl/pk_dbl_to_i32_chk.sv
module pk_dbl_to_i32_chk #(
    parameter int RES_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [RES_W-1:0] out_result,
    input logic             out_inv,
    input logic             out_prec,
    input logic             exc_strobe
);
    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result)
                                       && $stable(out_inv) && $stable(out_prec)));

    assert_hold_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_strobe |=> !exc_strobe);

    assert_strobe_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_strobe |-> ($stable(out_result) && out_inv && !in_ready));

    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, exc_strobe}));

    assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid || exc_strobe));

    assert_idle_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && !exc_strobe) |-> in_ready);
endmodule

bind pk_dbl_to_i32 pk_dbl_to_i32_chk #(.RES_W(N_LANES * pk_cvt_pkg::INT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_result (out_result),
    .out_inv    (out_inv),
    .out_prec   (out_prec),
    .exc_strobe (exc_strobe)
);

// File: tb/pk_dbl_to_i32_test.sv
`timescale 1ns/100ps
module pk_dbl_to_i32_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_opnd = '0;
    logic [1:0]   in_rmode = 2'b00;
    logic         in_inv_mask = 1'b1;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [63:0]  out_result;
    logic         out_inv;
    logic         out_prec;
    logic         exc_strobe;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] lcg = 32'h1234_5678;

    always #2.5 clk = ~clk;

    pk_dbl_to_i32 uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_opnd(in_opnd), .in_rmode(in_rmode), .in_inv_mask(in_inv_mask),
        .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
        .out_inv(out_inv), .out_prec(out_prec), .exc_strobe(exc_strobe)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    // reference: real arithmetic, independent of the RTL structure
    task automatic ref_lane(input logic [63:0] d, input logic [1:0] rm,
                            output logic [31:0] v, output logic inv, output logic inx);
        real x, fl, fr, r;
        inv = 1'b0;
        inx = 1'b0;
        v = 32'h0;
        if (d[62:52] == 11'h7FF) begin
            inv = 1'b1;
            v = 32'h8000_0000;
        end else if (d[62:52] == 11'h000) begin
            inx = (d[51:0] != 0);
        end else begin
            x = $bitstoreal(d);
            fl = $floor(x);
            fr = x - fl;
            case (rm)
                2'b00: begin
                    if (fr > 0.5) r = fl + 1.0;
                    else if (fr < 0.5) r = fl;
                    else if ($floor(fl / 2.0) * 2.0 == fl) r = fl;
                    else r = fl + 1.0;
                end
                2'b01: r = fl;
                2'b10: r = (fr > 0.0) ? fl + 1.0 : fl;
                default: r = (x >= 0.0) ? fl : ((fr > 0.0) ? fl + 1.0 : fl);
            endcase
            if (r > 2147483647.0 || r < -2147483648.0) begin
                inv = 1'b1;
                v = 32'h8000_0000;
            end else begin
                v = 32'($rtoi(r));
                inx = (fr != 0.0);
            end
        end
    endtask

    task automatic send(input logic [127:0] op, input logic [1:0] rm, input logic mask);
        @(negedge clk);
        in_opnd = op;
        in_rmode = rm;
        in_inv_mask = mask;
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    // masked operation compared lane by lane with the model
    task automatic run_op(input logic [63:0] hi, input logic [63:0] lo,
                          input logic [1:0] rm, input string req);
        logic [31:0] e0, e1;
        logic i0, i1, x0, x1;
        ref_lane(lo, rm, e0, i0, x0);
        ref_lane(hi, rm, e1, i1, x1);
        send({hi, lo}, rm, 1'b1);
        check(out_valid === 1'b1, {req, " R8 out_valid"}, 64'(out_valid), 64'd1);
        check(out_result[31:0] === e0, {req, " R1 lane0"}, 64'(out_result[31:0]), 64'(e0));
        check(out_result[63:32] === e1, {req, " R1 lane1"}, 64'(out_result[63:32]), 64'(e1));
        check(out_inv === (i0 | i1), {req, " R4 inv"}, 64'(out_inv), 64'(i0 | i1));
        check(out_prec === (x0 | x1), {req, " R4 prec"}, 64'(out_prec), 64'(x0 | x1));
    endtask

    task automatic t_reset();
        check(out_valid === 1'b0, "R11 out_valid", 64'(out_valid), 64'd0);
        check(exc_strobe === 1'b0, "R11 exc_strobe", 64'(exc_strobe), 64'd0);
        check(in_ready === 1'b1, "R11 in_ready", 64'(in_ready), 64'd1);
        check(out_result === 64'h0, "R11 out_result", out_result, 64'h0);
        check({out_inv, out_prec} === 2'b00, "R11 flags", 64'({out_inv, out_prec}), 64'd0);
    endtask

    task automatic t_exact();
        for (int m = 0; m < 4; m++) begin
            run_op($realtobits(-7.0), $realtobits(5.0), 2'(m), "R2 exact");
            check(out_result === {32'hFFFF_FFF9, 32'h0000_0005}, "R2 values",
                  out_result, {32'hFFFF_FFF9, 32'h0000_0005});
        end
        run_op($realtobits(-2147483648.0), $realtobits(2147483647.0), 2'b00, "R2 extremes");
        check(out_result === 64'h8000_0000_7FFF_FFFF && !out_inv && !out_prec, "R2 extremes",
              out_result, 64'h8000_0000_7FFF_FFFF);
    endtask

    task automatic t_rounding();
        real vals[8] = '{2.5, -2.5, 3.5, 1.4, -1.6, 0.5, -0.3, 0.7};
        for (int m = 0; m < 4; m++)
            for (int k = 0; k < 8; k += 2)
                run_op($realtobits(vals[k+1]), $realtobits(vals[k]), 2'(m), "R3 rounding");
        // nearest-even: 2.5 -> 2, 3.5 -> 4; down: -2.5 -> -3; up: 1.4 -> 2; zero: -1.6 -> -1
        run_op($realtobits(3.5), $realtobits(2.5), 2'b00, "R3 ties even");
        check(out_result === {32'd4, 32'd2}, "R3 ties even", out_result, {32'd4, 32'd2});
        run_op($realtobits(-2.5), $realtobits(1.4), 2'b01, "R3 down");
        check(out_result === {32'hFFFF_FFFD, 32'd1}, "R3 down", out_result, {32'hFFFF_FFFD, 32'd1});
        run_op($realtobits(-2.5), $realtobits(1.4), 2'b10, "R3 up");
        check(out_result === {32'hFFFF_FFFE, 32'd2}, "R3 up", out_result, {32'hFFFF_FFFE, 32'd2});
        run_op($realtobits(-1.6), $realtobits(1.6), 2'b11, "R3 zero");
        check(out_result === {32'hFFFF_FFFF, 32'd1}, "R3 zero", out_result, {32'hFFFF_FFFF, 32'd1});
    endtask

    task automatic t_boundary();
        run_op($realtobits(0.0), $realtobits(-2147483648.4), 2'b11, "R5 rz low");
        check(!out_inv && out_prec && out_result[31:0] === 32'h8000_0000, "R5 rz low valid",
              64'({out_inv, out_prec}), 64'd1);
        run_op($realtobits(0.0), $realtobits(-2147483648.6), 2'b01, "R5 down low");
        check(out_inv && !out_prec && out_result[31:0] === 32'h8000_0000, "R5 down low invalid",
              64'({out_inv, out_prec}), 64'd2);
        run_op($realtobits(2147483647.5), $realtobits(2147483647.4), 2'b00, "R5 near high");
        check(out_inv && out_prec && out_result === 64'h8000_0000_7FFF_FFFF, "R5 near high",
              out_result, 64'h8000_0000_7FFF_FFFF);
        run_op($realtobits(2147483647.2), $realtobits(2147483648.0), 2'b10, "R5 up high");
        run_op($realtobits(-4.0e12), $realtobits(4.0e12), 2'b11, "R5 huge");
    endtask

    task automatic t_special();
        run_op(64'h7FF8_0000_0000_0000, 64'h7FF0_0000_0000_0001, 2'b00, "R6 nans");
        check(out_result === 64'h8000_0000_8000_0000 && out_inv, "R6 nans",
              out_result, 64'h8000_0000_8000_0000);
        run_op(64'hFFF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 2'b11, "R6 infs");
        check(out_result === 64'h8000_0000_8000_0000 && out_inv, "R6 infs",
              out_result, 64'h8000_0000_8000_0000);
        for (int m = 0; m < 4; m++) begin
            run_op(64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001, 2'(m), "R7 denorm");
            check(out_result === 64'h0 && !out_inv && out_prec, "R7 denorm",
                  out_result, 64'h0);
        end
        run_op(64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000, 2'b10, "R7 zeros");
        check(out_result === 64'h0 && !out_inv && !out_prec, "R7 zeros",
              64'({out_inv, out_prec}), 64'h0);
    endtask

    task automatic t_merge();
        run_op(64'h7FF8_0000_0000_0000, $realtobits(6.25), 2'b11, "R4 mixed");
        check(out_inv && out_prec && out_result === 64'h8000_0000_0000_0006, "R4 mixed",
              out_result, 64'h8000_0000_0000_0006);
        run_op($realtobits(9.0), $realtobits(-3.0e10), 2'b00, "R4 invalid inexact lane");
        check(out_inv && !out_prec && out_result === 64'h0000_0009_8000_0000, "R4 no prec",
              out_result, 64'h0000_0009_8000_0000);
    endtask

    task automatic t_trap();
        logic [63:0] prev;
        run_op($realtobits(11.0), $realtobits(-12.0), 2'b00, "R10 setup");
        prev = out_result;
        send({$realtobits(1.0), 64'h7FF0_0000_0000_0000}, 2'b00, 1'b0);
        check(exc_strobe === 1'b1, "R10 strobe", 64'(exc_strobe), 64'd1);
        check(out_valid === 1'b0, "R10 no valid", 64'(out_valid), 64'd0);
        check(out_result === prev, "R10 result kept", out_result, prev);
        check(out_inv === 1'b1 && in_ready === 1'b0, "R10 inv/in_ready",
              64'({out_inv, in_ready}), 64'd2);
        @(posedge clk);
        #1;
        check(exc_strobe === 1'b0 && out_valid === 1'b0, "R10 strobe one cycle",
              64'({exc_strobe, out_valid}), 64'd0);
        check(in_ready === 1'b1 && out_result === prev, "R10 back to empty",
              out_result, prev);
        // unmasked but all valid: normal completion
        send({$realtobits(2.0), $realtobits(3.0)}, 2'b00, 1'b0);
        check(out_valid && !exc_strobe && out_result === {32'd2, 32'd3}, "R10 unmasked ok",
              out_result, {32'd2, 32'd3});
    endtask

    task automatic t_handshake();
        logic [63:0] held;
        run_op($realtobits(100.0), $realtobits(200.0), 2'b00, "R8 setup");
        held = out_result;
        @(negedge clk);
        out_ready = 1'b0;
        in_opnd = {$realtobits(1.0), $realtobits(2.0)};
        in_rmode = 2'b00;
        in_inv_mask = 1'b1;
        in_valid = 1'b1;
        #1;
        check(in_ready === 1'b0, "R9 in_ready low", 64'(in_ready), 64'd0);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            #1;
            check(out_valid === 1'b1 && out_result === held, "R9 hold", out_result, held);
        end
        @(negedge clk);
        out_ready = 1'b1;
        #1;
        check(in_ready === 1'b1, "R8 ready when taken", 64'(in_ready), 64'd1);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        check(out_valid === 1'b1 && out_result === {32'd1, 32'd2}, "R8 back to back",
              out_result, {32'd1, 32'd2});
        @(posedge clk);
        #1;
        check(out_valid === 1'b0 && in_ready === 1'b1, "R8 drain",
              64'({out_valid, in_ready}), 64'd1);
    endtask

    task automatic t_random();
        logic [63:0] a, b;
        real off;
        for (int i = 0; i < 300; i++) begin
            off = real'(int'(rnd() % 32'd6000) - 3000) / 1000.0;
            a = $realtobits(((rnd() & 1) != 0 ? -2147483648.0 : 2147483648.0) + off);
            b = {rnd(), rnd()};
            b[62:52] = 11'd1000 + 11'(rnd() % 32'd60);
            run_op(a, b, 2'(i), "R3 random");
            run_op(b, a, 2'(i + 1), "R5 random");
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_exact();
        t_rounding();
        t_boundary();
        t_special();
        t_merge();
        t_trap();
        t_handshake();
        t_random();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule